// File: doc/BRIEF.md
# Address-Selected SPI Slave Responder

This block is an SPI slave for a bus shared by several slaves with no per-slave select line. Every slave watches the same fixed-length command frame from the master. Byte 0 of that frame carries the target address. The slave whose own address matches that byte raises a one-cycle hit pulse to its local logic. Local logic answers by writing the response bytes through a parallel write port and then pulsing a ready strobe.

The master does not know in advance when the answer will be ready. After the command it keeps clocking 0xFF and treats each 0xFF it reads back as "not yet". Until the answer is ready, the addressed slave shifts out 0xFF with its output driver off, which is the same value a pulled-high, undriven line reads. At the next byte boundary after the ready strobe, the slave turns its driver on and sends one acknowledge byte that is not 0xFF. The data bytes follow at once. After the last data byte the slave returns to 0xFF and turns the driver off again.

The serial clock is sampled with the system clock. Framing is held by a bit counter and a command byte counter. A resync input puts both counters back to a frame start, which recovers alignment after a stray clock edge.

Top module: `spiAddrResponder`

## Requirements
- R1: After reset, `miso` is 1, `misoEn` is 0 and `cmdHit` is 0.
- R2: When byte 0 (the first byte, sent MSB first, sampled on rising `sclk`) of a 6-byte command frame equals `ownAddr`, `cmdHit` pulses high for exactly one clock after the frame's 48th rising edge.
- R3: For a frame whose address byte differs from `ownAddr`, there is no `cmdHit`, `misoEn` stays 0 and every byte read from `miso` is 0xFF.
- R4: An `ownAddr` of 0xFF never matches, not even a frame addressed to 0xFF.
- R5: While an answer is pending and not yet ready, each byte the slave shifts out is 0xFF with `misoEn` at 0.
- R6: After `rspReady`, the next whole byte is ACK_VAL (default 0xA5) with `misoEn` at 1. The DATA_BYTES (default 4) bytes follow, in the order they were written and with `misoEn` at 1. Then comes 0xFF with `misoEn` at 0.
- R7: If `rspReady` arrives before the boundary that ends the command frame, the acknowledge byte is the very first byte after the frame, with no filler byte.
- R8: A ready strobe given partway through a byte leaves that byte intact (0xFF) and takes effect only at the following boundary.
- R9: `rspReady` while no answer is pending is ignored, so later bytes stay 0xFF with `misoEn` at 0.
- R10: One stray `sclk` pulse before a frame misaligns the frame so that it does not match. After a `resync` pulse, the same frame matches again.
- R11: Response writes after DATA_BYTES writes following a hit are dropped, so the data sent is the first DATA_BYTES written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst | input | 1 | Synchronous reset, active high |
| resync | input | 1 | Returns bit and byte counters to a frame start and drops any pending answer |
| ownAddr | input | 8 | Address this slave answers to |
| sclk | input | 1 | Serial clock from the master, idle low |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |
| misoEn | output | 1 | Output-driver enable for `miso` |
| rspData | input | 8 | Response byte from local logic |
| rspWr | input | 1 | Write strobe for `rspData` |
| rspReady | input | 1 | Answer-ready strobe |
| cmdHit | output | 1 | One-cycle pulse when a matching frame completes |

## Verification
A wrong byte or bit count shows first as a missing or misplaced `cmdHit` at the end of a frame. It can also show as an acknowledge byte arriving one byte early or late, which the master-side bench sees within a single byte time. A wrong response-state value shows as `misoEn` high on a filler byte, or low on an acknowledge or data byte, on the very byte it affects. A load away from a byte boundary shows as a torn filler byte read back as something other than 0xFF.

// File: rtl/spiRspPkg.sv
package spiRspPkg;
  localparam int IDX_W = 8;

  typedef enum logic [1:0] {
    TX_FILL,
    TX_ACK,
    TX_DATA
  } txSel_e;

  typedef struct packed {
    txSel_e           sel;
    logic [IDX_W-1:0] idx;
    logic             clrPtr;
  } ctlStrobe_t;
endpackage

// File: rtl/spiRspDatapath.sv
module spiRspDatapath
  import spiRspPkg::*;
#(
  parameter int                BYTE_W     = 8,
  parameter int                DATA_BYTES = 4,
  parameter logic [BYTE_W-1:0] FILL_VAL   = '1,
  parameter logic [BYTE_W-1:0] ACK_VAL    = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              resync,
  input  logic              sclk,
  input  logic              mosi,
  input  ctlStrobe_t        ctl,
  input  logic              wrEn,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rxByte,
  output logic              byteDone,
  output logic              loadNow,
  output logic              miso
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam int PTR_W = $clog2(DATA_BYTES + 1);

  logic              sclkS, sclkD, mosiS;
  logic              rise, fall;
  logic [BIT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] txShift;
  logic [BYTE_W-1:0] txNext;
  logic [BYTE_W-1:0] rspBuf [DATA_BYTES];
  logic [PTR_W-1:0]  wrPtr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclkS <= 1'b0;
      sclkD <= 1'b0;
      mosiS <= 1'b0;
    end else begin
      sclkS <= sclk;
      sclkD <= sclkS;
      mosiS <= mosi;
    end
  end

  assign rise    = sclkS & ~sclkD;
  assign fall    = ~sclkS & sclkD;
  assign loadNow = fall && (bitCnt == '0);

  always_ff @(posedge clk) begin
    if (rst || resync) begin
      bitCnt   <= '0;
      rxShift  <= '0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= rise && (bitCnt == BIT_W'(BYTE_W - 1));
      if (rise) begin
        rxShift <= {rxShift[BYTE_W-2:0], mosiS};
        bitCnt  <= (bitCnt == BIT_W'(BYTE_W - 1)) ? '0 : bitCnt + 1'b1;
      end
    end
  end

  assign rxByte = rxShift;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
    end else if (ctl.clrPtr) begin
      wrPtr <= '0;
    end else if (wrEn && (wrPtr < PTR_W'(DATA_BYTES))) begin
      wrPtr <= wrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DATA_BYTES; i++) begin
      if (!rst && !ctl.clrPtr && wrEn && (wrPtr == PTR_W'(i))) rspBuf[i] <= wrData;
    end
  end

  always_comb begin
    txNext = FILL_VAL;
    unique case (ctl.sel)
      TX_ACK:  txNext = ACK_VAL;
      TX_DATA: begin
        for (int i = 0; i < DATA_BYTES; i++) begin
          if (ctl.idx == IDX_W'(i)) txNext = rspBuf[i];
        end
      end
      default: txNext = FILL_VAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || resync) begin
      txShift <= FILL_VAL;
    end else if (loadNow) begin
      txShift <= txNext;
    end else if (fall) begin
      txShift <= {txShift[BYTE_W-2:0], 1'b1};
    end
  end

  assign miso = txShift[BYTE_W-1];

  // R8: the shifter moves only on a falling serial edge or a resync
  p_tx_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (!fall && !resync) |=> (txShift == $past(txShift)));
endmodule

// File: rtl/spiRspControl.sv
module spiRspControl
  import spiRspPkg::*;
#(
  parameter int                BYTE_W      = 8,
  parameter int                FRAME_BYTES = 6,
  parameter int                DATA_BYTES  = 4,
  parameter int                ADDR_IDX    = 0,
  parameter logic [BYTE_W-1:0] FILL_VAL    = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              resync,
  input  logic [BYTE_W-1:0] ownAddr,
  input  logic              byteDone,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              loadNow,
  input  logic              rspReady,
  output ctlStrobe_t        ctl,
  output logic              cmdHit,
  output logic              misoEn
);
  localparam int                CNT_W    = $clog2(FRAME_BYTES);
  localparam logic [CNT_W-1:0]  LAST_CNT = CNT_W'(FRAME_BYTES - 1);
  localparam logic [CNT_W-1:0]  ADDR_CNT = CNT_W'(ADDR_IDX);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(DATA_BYTES - 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DATA, S_TAIL} state_e;

  state_e           state;
  logic [CNT_W-1:0] byteCnt;
  logic             addrOk;
  logic             readyFlag;
  logic [IDX_W-1:0] dataIdx;

  always_ff @(posedge clk) begin
    if (rst || resync) begin
      state     <= S_IDLE;
      byteCnt   <= '0;
      addrOk    <= 1'b0;
      readyFlag <= 1'b0;
      misoEn    <= 1'b0;
      dataIdx   <= '0;
      cmdHit    <= 1'b0;
    end else begin
      cmdHit <= 1'b0;
      if (state == S_WAIT && rspReady) readyFlag <= 1'b1;
      unique case (state)
        S_IDLE: begin
          if (byteDone) begin
            if (byteCnt == ADDR_CNT)
              addrOk <= (rxByte == ownAddr) && (ownAddr != FILL_VAL);
            if (byteCnt == LAST_CNT) begin
              byteCnt <= '0;
              addrOk  <= 1'b0;
              if (addrOk) begin
                state  <= S_WAIT;
                cmdHit <= 1'b1;
              end
            end else begin
              byteCnt <= byteCnt + 1'b1;
            end
          end
        end
        S_WAIT: begin
          if (loadNow && readyFlag) begin
            state     <= S_DATA;
            dataIdx   <= '0;
            misoEn    <= 1'b1;
            readyFlag <= 1'b0;
          end
        end
        S_DATA: begin
          if (loadNow) begin
            if (dataIdx == LAST_IDX) state <= S_TAIL;
            else dataIdx <= dataIdx + 1'b1;
          end
        end
        S_TAIL: begin
          if (loadNow) begin
            state  <= S_IDLE;
            misoEn <= 1'b0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.idx    = dataIdx;
    ctl.clrPtr = cmdHit;
    if (state == S_WAIT && readyFlag) ctl.sel = TX_ACK;
    else if (state == S_DATA)         ctl.sel = TX_DATA;
    else                              ctl.sel = TX_FILL;
  end

  p_hit_single_r2: assert property (@(posedge clk) disable iff (rst)
    cmdHit |=> !cmdHit);

  p_ff_never_r4: assert property (@(posedge clk) disable iff (rst)
    cmdHit |-> ($past(ownAddr) != FILL_VAL));

  p_en_rise_boundary_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(misoEn) |-> $past(loadNow));

  p_en_fall_boundary_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(misoEn) |-> ($past(loadNow) || $past(resync)));
endmodule

// File: rtl/spiAddrResponder.sv
module spiAddrResponder
  import spiRspPkg::*;
#(
  parameter int                BYTE_W      = 8,
  parameter int                FRAME_BYTES = 6,
  parameter int                DATA_BYTES  = 4,
  parameter int                ADDR_IDX    = 0,
  parameter logic [BYTE_W-1:0] FILL_VAL    = '1,
  parameter logic [BYTE_W-1:0] ACK_VAL     = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              resync,
  input  logic [BYTE_W-1:0] ownAddr,
  input  logic              sclk,
  input  logic              mosi,
  output logic              miso,
  output logic              misoEn,
  input  logic [BYTE_W-1:0] rspData,
  input  logic              rspWr,
  input  logic              rspReady,
  output logic              cmdHit
);
  ctlStrobe_t        ctl;
  logic [BYTE_W-1:0] rxByte;
  logic              byteDone;
  logic              loadNow;

  spiRspDatapath #(
    .BYTE_W(BYTE_W), .DATA_BYTES(DATA_BYTES),
    .FILL_VAL(FILL_VAL), .ACK_VAL(ACK_VAL)
  ) uDp (
    .clk(clk), .rst(rst), .resync(resync), .sclk(sclk), .mosi(mosi),
    .ctl(ctl), .wrEn(rspWr), .wrData(rspData), .rxByte(rxByte),
    .byteDone(byteDone), .loadNow(loadNow), .miso(miso)
  );

  spiRspControl #(
    .BYTE_W(BYTE_W), .FRAME_BYTES(FRAME_BYTES), .DATA_BYTES(DATA_BYTES),
    .ADDR_IDX(ADDR_IDX), .FILL_VAL(FILL_VAL)
  ) uCtl (
    .clk(clk), .rst(rst), .resync(resync), .ownAddr(ownAddr),
    .byteDone(byteDone), .rxByte(rxByte), .loadNow(loadNow),
    .rspReady(rspReady), .ctl(ctl), .cmdHit(cmdHit), .misoEn(misoEn)
  );
endmodule

// File: tb/tb_spiAddrResponder.sv
module tb_spiAddrResponder;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 12;
  localparam int NDATA      = 4;
  localparam logic [7:0] ACK = 8'hA5;

  // {ownAddr, frame address, filler index carrying ready, hit expected}
  localparam int NVEC = 5;
  localparam logic [20:0] VECS [NVEC] = '{
    {8'h5A, 8'h5A, 4'd0, 1'b1},
    {8'h3C, 8'h3C, 4'd3, 1'b1},
    {8'h5A, 8'h5B, 4'd0, 1'b0},
    {8'hFF, 8'hFF, 4'd0, 1'b0},
    {8'h01, 8'h01, 4'd1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic resync = 1'b0;
  logic [7:0] ownAddr = 8'h00;
  logic sclk = 1'b0;
  logic mosi = 1'b0;
  logic miso, misoEn, cmdHit;
  logic [7:0] rspData = 8'h00;
  logic rspWr = 1'b0;
  logic rspReady = 1'b0;

  int nRun = 0;
  int nFail = 0;
  int hitCnt = 0;
  logic [7:0] curBase = 8'h00;
  int curExtra = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spiAddrResponder dut (
    .clk(clk), .rst(rst), .resync(resync), .ownAddr(ownAddr),
    .sclk(sclk), .mosi(mosi), .miso(miso), .misoEn(misoEn),
    .rspData(rspData), .rspWr(rspWr), .rspReady(rspReady), .cmdHit(cmdHit)
  );

  always @(posedge clk) if (!rst && cmdHit) hitCnt <= hitCnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic pulseReady();
    @(negedge clk) rspReady = 1'b1;
    @(negedge clk) rspReady = 1'b0;
  endtask

  task automatic loadData();
    for (int j = 0; j < NDATA + curExtra; j++) begin
      @(negedge clk);
      rspWr = 1'b1;
      rspData = curBase + 8'(j);
    end
    @(negedge clk) rspWr = 1'b0;
  endtask

  task automatic doResync();
    @(negedge clk) resync = 1'b1;
    @(negedge clk) resync = 1'b0;
  endtask

  // mode 0: plain, 1: ready strobe mid-byte, 2: data load and ready after the last rising edge
  task automatic xfer(input logic [7:0] tx, input int mode,
                      output logic [7:0] rx, output logic en);
    en = 1'b0;
    for (int b = 7; b >= 0; b--) begin
      mosi = tx[b];
      repeat (HALF) @(negedge clk);
      rx[b] = miso;
      if (b == 4) en = misoEn;
      if (mode == 1 && b == 3) pulseReady();
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      if (mode == 2 && b == 0) begin
        loadData();
        pulseReady();
      end
      sclk = 1'b0;
    end
  endtask

  task automatic sendFrame(input logic [7:0] addr, input int lastMode);
    logic [7:0] rx;
    logic en;
    for (int k = 0; k < 6; k++) begin
      xfer((k == 0) ? addr : 8'(k), (k == 5) ? lastMode : 0, rx, en);
    end
  endtask

  task automatic expectByte(input int mode, input logic [7:0] expVal,
                            input logic expEn, input string req);
    logic [7:0] rx;
    logic en;
    xfer(8'hFF, mode, rx, en);
    chk(rx == expVal, req, rx, expVal);
    chk(en == expEn, req, en, expEn);
  endtask

  task automatic expectResponse(input string req);
    expectByte(0, ACK, 1'b1, req);
    for (int j = 0; j < NDATA; j++) expectByte(0, curBase + 8'(j), 1'b1, req);
    expectByte(0, 8'hFF, 1'b0, req);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    int h0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(miso == 1'b1, "R1 miso", miso, 1);
    chk(misoEn == 1'b0, "R1 misoEn", misoEn, 0);
    chk(cmdHit == 1'b0, "R1 cmdHit", cmdHit, 0);

    // Table of vectors: R2, R3, R4, R5, R6, R8
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] own, addr;
      int ra;
      bit expHit;
      own = VECS[v][20:13];
      addr = VECS[v][12:5];
      ra = int'(VECS[v][4:1]);
      expHit = VECS[v][0];
      ownAddr = own;
      curBase = 8'h40 + 8'(v * 8);
      curExtra = 0;
      h0 = hitCnt;
      sendFrame(addr, 0);
      repeat (4) @(negedge clk);
      if (expHit) begin
        chk(hitCnt == h0 + 1, "R2 hit count", hitCnt - h0, 1);
        loadData();
        for (int b = 0; b <= ra; b++)
          expectByte((b == ra) ? 1 : 0, 8'hFF, 1'b0, (b == ra) ? "R8 filler kept" : "R5 filler");
        expectResponse("R6 sequence");
      end else begin
        chk(hitCnt == h0, (own == 8'hFF) ? "R4 no match" : "R3 no match", hitCnt - h0, 0);
        for (int b = 0; b < 4; b++)
          expectByte((b == 0) ? 1 : 0, 8'hFF, 1'b0, (own == 8'hFF) ? "R4 silent" : "R3 silent");
      end
      doResync();
    end

    // R9: ready with no answer pending
    ownAddr = 8'h22;
    expectByte(1, 8'hFF, 1'b0, "R9 idle ready");
    expectByte(0, 8'hFF, 1'b0, "R9 idle ready");
    doResync();

    // R7 and R11: ready before the frame boundary, one extra write
    ownAddr = 8'h77;
    curBase = 8'hC0;
    curExtra = 1;
    h0 = hitCnt;
    sendFrame(8'h77, 2);
    chk(hitCnt == h0 + 1, "R7 hit", hitCnt - h0, 1);
    expectByte(0, ACK, 1'b1, "R7 immediate ack");
    for (int j = 0; j < NDATA; j++) expectByte(0, curBase + 8'(j), 1'b1, "R11 first writes kept");
    expectByte(0, 8'hFF, 1'b0, "R6 tail");
    doResync();
    curExtra = 0;

    // R10: stray edge misaligns, resync recovers
    ownAddr = 8'h5A;
    mosi = 1'b0;
    repeat (HALF) @(negedge clk);
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
    h0 = hitCnt;
    sendFrame(8'h5A, 0);
    repeat (4) @(negedge clk);
    chk(hitCnt == h0, "R10 misaligned", hitCnt - h0, 0);
    expectByte(0, 8'hFF, 1'b0, "R10 misaligned silent");
    doResync();
    curBase = 8'h10;
    sendFrame(8'h5A, 0);
    repeat (4) @(negedge clk);
    chk(hitCnt == h0 + 1, "R10 realigned", hitCnt - h0, 1);
    loadData();
    expectByte(1, 8'hFF, 1'b0, "R10 filler");
    expectResponse("R10 response");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule